// File: doc/BRIEF.md
# Fail Detection and Trap Supervisor

This block watches a processor for two kinds of failure and turns them into a latched fail indication and, when allowed, a trap request. The first failure is an instruction that never finishes: the sequence step counter is supposed to be reset before it passes its last legal step. If its most significant bit ever becomes 1, no sequence ended, and the opcode is treated as invalid. The second failure is a peripheral that holds its WAIT line too long. After a fixed number of consecutive WAIT cycles, the block forces the transfer to resume. It then masks WAIT for a fixed window, so a stuck device cannot freeze the machine again straight away.

Either failure sets a fail flip-flop. That flip-flop drives the console FAIL lamp and stays set until the operator presses clear or the processor takes the trap. A trap is requested only when all of the following hold:
- the software trap-enable flip-flop is set;
- the console trap switch is on;
- the halt-on-fail switch is off.

The request carries a fixed vector pointer address. It stays up until the processor acknowledges it. The acknowledge also clears the fail flip-flop.

Top module: `fail_supervisor`

## Requirements
- R1: When bit 3 (the most significant bit) of `step_cnt` is 1 at a clock edge, `fail_lamp` is 1 after that edge.
- R2: When `wait_in` has been 1 at 32 consecutive clock edges outside the ignore window, `wait_release` and `fail_lamp` are both 1 after the 32nd edge. After 31 such edges both are still 0.
- R3: `wait_release` stays 1 for exactly 32 clock cycles and then returns to 0. While it is 1, `wait_eff` is 0 whatever `wait_in` is. At all other times `wait_eff` equals `wait_in`.
- R4: A single cycle with `wait_in` at 0 before the limit restarts the count. A new timeout then needs 32 further consecutive WAIT edges.
- R5: Once set, `fail_lamp` stays 1 until `clr_btn` is 1 at an edge, or until a trap is taken (`trap_ack` at 1 while `trap_req` is 1). Either of these clears it at that edge. A new fail event at the same edge wins over the clear.
- R6: The trap-enable flip-flop is 0 after reset. `te_set` at 1 sets it, and `te_clr` at 1 clears it; `te_clr` wins when both are 1. The new value affects only fail events at later edges.
- R7: A fail event sets `trap_req` only if, at that edge, trap-enable is 1, `trap_sw` is 1 and `hof_sw` is 0. Otherwise `trap_req` stays 0.
- R8: `trap_req` stays 1 until `trap_ack` is 1 at an edge. That edge clears both `trap_req` and `fail_lamp`. `clr_btn` alone does not clear `trap_req`.
- R9: `trap_vec` is always 12'h010.
- R10: After reset, `fail_lamp`, `wait_release` and `trap_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_cnt | input | 4 | Sequence step count from the timing generator |
| wait_in | input | 1 | Raw WAIT from the peripheral channel, active high |
| clr_btn | input | 1 | Console clear button, active high |
| te_set | input | 1 | Software request to set trap-enable |
| te_clr | input | 1 | Software request to clear trap-enable |
| trap_sw | input | 1 | Console trap switch, 1 = on |
| hof_sw | input | 1 | Console halt-on-fail switch, 1 = on |
| trap_ack | input | 1 | Processor has taken the trap |
| fail_lamp | output | 1 | Fail flip-flop, drives the FAIL lamp |
| wait_release | output | 1 | Forced WAIT release, high during the ignore window |
| wait_eff | output | 1 | WAIT as the processor should see it |
| trap_req | output | 1 | Trap request to the processor |
| trap_vec | output | 12 | Address of the trap routine pointer |

## Verification
On every cycle, the assertions check the following:
- an invalid step count sets the lamp at the next edge;
- WAIT stays masked while the release is active;
- the release never runs longer than its window;
- the lamp and the trap request hold until their clearing inputs arrive;
- a trap request only rises when both console switches allowed it.

Some behaviour only the bench scenarios can show:
- the exact 32-edge timeout and window lengths;
- the count restarting after a short WAIT drop;
- the trap-enable flip-flop being clear after reset;
- no trap request when only one gating condition is missing.

// File: rtl/fail_sup_pkg.sv
package fail_sup_pkg;
  parameter int unsigned DEF_STEP_W     = 4;
  parameter int unsigned DEF_WAIT_LIMIT = 32;
  parameter int unsigned DEF_IGN_LEN    = 32;
  parameter int unsigned DEF_ADDR_W     = 12;
  parameter int unsigned DEF_TRAP_VEC   = 16;
endpackage

// File: rtl/fail_wait_wdog.sv
module fail_wait_wdog #(
  parameter int unsigned WAIT_LIMIT = 32,
  parameter int unsigned IGN_LEN    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_in,
  output logic timeout,
  output logic ignoring,
  output logic wait_eff
);
  localparam int unsigned CNT_W = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
  localparam int unsigned IGN_W = (IGN_LEN > 1) ? $clog2(IGN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_LIMIT - 1);
  localparam logic [IGN_W-1:0] IGN_LAST = IGN_W'(IGN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IGN_W-1:0] ign_cnt_q, ign_cnt_d;
  logic             ign_q, ign_d;
  logic             cnt_en, ign_en;

  always_comb begin
    timeout   = !ign_q && wait_in && (cnt_q == CNT_LAST);
    cnt_en    = 1'b1;
    if (ign_q || !wait_in || timeout) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    ign_en    = timeout || ign_q;
    ign_d     = ign_q;
    ign_cnt_d = ign_cnt_q;
    if (timeout) begin
      ign_d     = 1'b1;
      ign_cnt_d = '0;
    end else if (ign_q) begin
      if (ign_cnt_q == IGN_LAST) begin
        ign_d     = 1'b0;
        ign_cnt_d = '0;
      end else begin
        ign_cnt_d = ign_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ign_q     <= 1'b0;
      ign_cnt_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (ign_en) begin
        ign_q     <= ign_d;
        ign_cnt_q <= ign_cnt_d;
      end
    end
  end

  assign ignoring = ign_q;
  assign wait_eff = wait_in && !ign_q;
endmodule

// File: rtl/fail_trap_ctl.sv
module fail_trap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic clr_btn,
  input  logic te_set,
  input  logic te_clr,
  input  logic trap_sw,
  input  logic hof_sw,
  input  logic trap_ack,
  output logic fail_q,
  output logic te_q,
  output logic req_q
);
  logic fail_d, te_d, req_d, take, gate;
  logic te_en;

  always_comb begin
    take   = req_q && trap_ack;
    gate   = te_q && trap_sw && !hof_sw;
    fail_d = fail_evt || (fail_q && !clr_btn && !take);
    te_en  = te_set || te_clr;
    te_d   = te_clr ? 1'b0 : 1'b1;
    req_d  = (fail_evt && gate) || (req_q && !trap_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      te_q   <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      fail_q <= fail_d;
      if (te_en) te_q <= te_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/fail_supervisor.sv
module fail_supervisor
  import fail_sup_pkg::*;
#(
  parameter int unsigned STEP_W     = DEF_STEP_W,
  parameter int unsigned WAIT_LIMIT = DEF_WAIT_LIMIT,
  parameter int unsigned IGN_LEN    = DEF_IGN_LEN,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned TRAP_VEC   = DEF_TRAP_VEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step_cnt,
  input  logic              wait_in,
  input  logic              clr_btn,
  input  logic              te_set,
  input  logic              te_clr,
  input  logic              trap_sw,
  input  logic              hof_sw,
  input  logic              trap_ack,
  output logic              fail_lamp,
  output logic              wait_release,
  output logic              wait_eff,
  output logic              trap_req,
  output logic [ADDR_W-1:0] trap_vec
);
  localparam int unsigned STEP_MSB = STEP_W - 1;

  logic rst_meta, rst_sync_n;
  logic invalid_op, wd_timeout, fail_evt;
  logic te_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign invalid_op = step_cnt[STEP_MSB];
  assign fail_evt   = invalid_op || wd_timeout;

  fail_wait_wdog #(
    .WAIT_LIMIT(WAIT_LIMIT),
    .IGN_LEN   (IGN_LEN)
  ) i_wdog (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wait_in (wait_in),
    .timeout (wd_timeout),
    .ignoring(wait_release),
    .wait_eff(wait_eff)
  );

  fail_trap_ctl i_trap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fail_evt(fail_evt),
    .clr_btn (clr_btn),
    .te_set  (te_set),
    .te_clr  (te_clr),
    .trap_sw (trap_sw),
    .hof_sw  (hof_sw),
    .trap_ack(trap_ack),
    .fail_q  (fail_lamp),
    .te_q    (te_unused),
    .req_q   (trap_req)
  );

  assign trap_vec = ADDR_W'(TRAP_VEC);
endmodule

// File: rtl/fail_supervisor_chk.sv
module fail_supervisor_chk #(
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned IGN_LEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STEP_W-1:0] step_cnt,
  input logic              clr_btn,
  input logic              trap_sw,
  input logic              hof_sw,
  input logic              trap_ack,
  input logic              te_q,
  input logic              fail_lamp,
  input logic              wait_release,
  input logic              wait_eff,
  input logic              trap_req
);
  localparam int unsigned RUN_W = $clog2(IGN_LEN + 2) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (wait_release) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_INVALID_SETS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt[STEP_W-1] |=> fail_lamp); // R1
  AST_RELEASE_MASKS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_release |-> !wait_eff); // R3
  AST_RELEASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(IGN_LEN)); // R3
  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_lamp && !clr_btn && !(trap_req && trap_ack)) |=> fail_lamp); // R5
  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req ##1 trap_req) |-> $past(te_q && trap_sw && !hof_sw)); // R7
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_ack) |=> trap_req); // R8
endmodule

bind fail_supervisor fail_supervisor_chk #(
  .STEP_W (STEP_W),
  .IGN_LEN(IGN_LEN)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .step_cnt    (step_cnt),
  .clr_btn     (clr_btn),
  .trap_sw     (trap_sw),
  .hof_sw      (hof_sw),
  .trap_ack    (trap_ack),
  .te_q        (i_trap.te_q),
  .fail_lamp   (fail_lamp),
  .wait_release(wait_release),
  .wait_eff    (wait_eff),
  .trap_req    (trap_req)
);

// File: tb/test_fail_supervisor.sv
module test_fail_supervisor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  step_cnt;
  logic        wait_in, clr_btn, te_set, te_clr, trap_sw, hof_sw, trap_ack;
  logic        fail_lamp, wait_release, wait_eff, trap_req;
  logic [11:0] trap_vec;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  fail_supervisor i_fail_supervisor (
    .clk(clk), .rst_n(rst_n), .step_cnt(step_cnt), .wait_in(wait_in),
    .clr_btn(clr_btn), .te_set(te_set), .te_clr(te_clr), .trap_sw(trap_sw),
    .hof_sw(hof_sw), .trap_ack(trap_ack), .fail_lamp(fail_lamp),
    .wait_release(wait_release), .wait_eff(wait_eff), .trap_req(trap_req),
    .trap_vec(trap_vec)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    clr_btn = 1'b1; tick(1); clr_btn = 1'b0;
  endtask

  task automatic pulse_invalid();
    step_cnt = 4'd8; tick(1); step_cnt = 4'd0;
  endtask

  task automatic t_reset();
    step_cnt = 0; wait_in = 0; clr_btn = 0; te_set = 0; te_clr = 0;
    trap_sw = 0; hof_sw = 0; trap_ack = 0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check("R10 fail_lamp", {31'd0, fail_lamp}, 32'd0);
    check("R10 wait_release", {31'd0, wait_release}, 32'd0);
    check("R10 trap_req", {31'd0, trap_req}, 32'd0);
    check("R9 trap_vec", {20'd0, trap_vec}, 32'h010);
  endtask

  task automatic t_invalid();
    step_cnt = 4'd7; tick(1);
    check("R1 step 7 no fail", {31'd0, fail_lamp}, 32'd0);
    pulse_invalid();
    check("R1 step 8 fail", {31'd0, fail_lamp}, 32'd1);
    tick(5);
    check("R5 fail holds", {31'd0, fail_lamp}, 32'd1);
    pulse_clr();
    check("R5 clr clears", {31'd0, fail_lamp}, 32'd0);
    step_cnt = 4'd8; clr_btn = 1'b1; tick(1); step_cnt = 0; clr_btn = 0;
    check("R5 set wins over clr", {31'd0, fail_lamp}, 32'd1);
    pulse_clr();
  endtask

  task automatic t_wait_timeout();
    wait_in = 1'b1;
    tick(31);
    check("R2 31 edges no release", {31'd0, wait_release}, 32'd0);
    check("R2 31 edges no fail", {31'd0, fail_lamp}, 32'd0);
    check("R3 wait passes", {31'd0, wait_eff}, 32'd1);
    tick(1);
    check("R2 release at 32", {31'd0, wait_release}, 32'd1);
    check("R2 fail at 32", {31'd0, fail_lamp}, 32'd1);
    check("R3 wait masked", {31'd0, wait_eff}, 32'd0);
    tick(31);
    check("R3 window still open", {31'd0, wait_release}, 32'd1);
    tick(1);
    check("R3 window closed", {31'd0, wait_release}, 32'd0);
    check("R3 wait passes again", {31'd0, wait_eff}, 32'd1);
    wait_in = 1'b0;
    pulse_clr();
    check("R3 wait follows low", {31'd0, wait_eff}, 32'd0);
  endtask

  task automatic t_wait_restart();
    wait_in = 1'b1; tick(20);
    wait_in = 1'b0; tick(1);
    wait_in = 1'b1; tick(31);
    check("R4 restart no release", {31'd0, wait_release}, 32'd0);
    check("R4 restart no fail", {31'd0, fail_lamp}, 32'd0);
    tick(1);
    check("R4 release after full run", {31'd0, wait_release}, 32'd1);
    wait_in = 1'b0;
    tick(32);
    check("R4 window done", {31'd0, wait_release}, 32'd0);
    pulse_clr();
  endtask

  task automatic t_trap_gate();
    trap_sw = 1'b1; hof_sw = 1'b0;
    pulse_invalid();
    check("R6 te clear after reset", {31'd0, trap_req}, 32'd0);
    pulse_clr();
    te_set = 1'b1; tick(1); te_set = 1'b0;
    hof_sw = 1'b1;
    pulse_invalid();
    check("R7 hof blocks trap", {31'd0, trap_req}, 32'd0);
    pulse_clr();
    hof_sw = 1'b0; trap_sw = 1'b0;
    pulse_invalid();
    check("R7 switch off blocks trap", {31'd0, trap_req}, 32'd0);
    pulse_clr();
    te_set = 1'b1; te_clr = 1'b1; tick(1); te_set = 0; te_clr = 0;
    trap_sw = 1'b1;
    pulse_invalid();
    check("R6 te_clr wins", {31'd0, trap_req}, 32'd0);
    pulse_clr();
  endtask

  task automatic t_trap_ack();
    te_set = 1'b1; tick(1); te_set = 1'b0;
    trap_sw = 1'b1; hof_sw = 1'b0;
    pulse_invalid();
    check("R7 trap raised", {31'd0, trap_req}, 32'd1);
    tick(6);
    check("R8 req holds", {31'd0, trap_req}, 32'd1);
    pulse_clr();
    check("R8 clr keeps req", {31'd0, trap_req}, 32'd1);
    check("R5 clr clears lamp", {31'd0, fail_lamp}, 32'd0);
    pulse_invalid();
    check("R5 lamp set again", {31'd0, fail_lamp}, 32'd1);
    trap_ack = 1'b1; tick(1); trap_ack = 1'b0;
    check("R8 ack clears req", {31'd0, trap_req}, 32'd0);
    check("R8 ack clears fail", {31'd0, fail_lamp}, 32'd0);
    check("R9 vec stable", {20'd0, trap_vec}, 32'h010);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_invalid();
    t_wait_timeout();
    t_wait_restart();
    t_trap_gate();
    t_trap_ack();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end
endmodule